// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block sits between a set of internal clock phase generators and the clock output pads of a system clock source. It produces eight groups of clock outputs: a processor group, one always-running memory clock, a bank of gateable memory clocks, a hub group, a bus group, a 48 MHz group, a reference output and an interrupt-controller group. Each output has its own gate cell. A gate cell can only close or open while its source phase is low. As a result, every stop and every restart produces full-width high pulses.

A two-bit mode select chooses how the block runs. One code tristates the pads. One code is a test mode that derives every output from an external test clock through fixed binary ratios. The remaining two codes are normal operation, with the processor group at the slower or the faster of two rates. An active-low asynchronous power-down input is synchronized and then qualified against the processor clock. When power-down is accepted, the block parks every output low and drops the oscillator and VCO run enables. A strap sampled during reset selects the rate of the interrupt-controller group.

Top module: `clkout_gate_seq`

## Requirements
- R1: While `rst` is high, every clock output and `drive_en` are 0.
- R2: With select 11 the processor outputs toggle every CPU_HALF_HI core cycles, and with select 10 every CPU_HALF_LO cycles. In both codes the memory, hub, bus, 48 MHz and reference outputs toggle every SDR_HALF, HUB_HALF, PCI_HALF, USB_HALF and REF_HALF cycles.
- R3: With select 01, for a test clock of period T, the outputs have these periods: reference T, processor and 48 MHz 2T, memory and hub 4T, bus 8T, interrupt-controller 16T.
- R4: With select 00, `drive_en` is 0 from the second cycle on. For every other code it is 1.
- R5: Power-down is accepted only after the synchronized `pd_n` is low on two consecutive processor-clock rising edges. A low pulse that spans fewer such edges has no effect.
- R6: Once power-down is accepted, every output (including `sdr_free`) finishes low, no output rises, and `osc_run` and `vco_run` are 0.
- R7: An output that stops, whether through power-down or through its enable bit, ends on a falling edge of its own phase. Its last high pulse has full width.
- R8: An enable bit of 0 holds the matching output low. The other outputs keep running.
- R9: `sdr_free` runs whatever the values of the enable inputs.
- R10: `apic_fast` is captured only while `rst` is high. A value of 1 gives a half period of APIC_HALF_HI, and 0 gives twice that. Changes after reset have no effect.
- R11: After power-down is released, or after an enable bit returns to 1, the output restarts on a rising edge of its own phase. Its first high pulse has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock feeding all dividers |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| fsel | input | 2 | Mode select: 00 tristate, 01 test, 10 slow processor, 11 fast processor |
| tclk | input | 1 | External test clock, used in test mode |
| apic_fast | input | 1 | Interrupt-controller rate strap, captured during reset |
| en_cpu | input | N_CPU | Per-output enables, processor group |
| en_sdr | input | N_SDR | Per-output enables, gated memory clocks |
| en_pci | input | N_PCI | Per-output enables, bus group |
| en_usb | input | N_USB | Per-output enables, 48 MHz group |
| cpu_clk | output | N_CPU | Processor clocks |
| sdr_free | output | 1 | Memory clock that ignores the enables |
| sdr_clk | output | N_SDR | Gated memory clocks |
| hub_clk | output | N_HUB | Hub clocks |
| pci_clk | output | N_PCI | Bus clocks |
| usb_clk | output | N_USB | 48 MHz clocks |
| ref_clk | output | 1 | Reference clock |
| apic_clk | output | N_APIC | Interrupt-controller clocks |
| drive_en | output | 1 | Pad drive enable; 0 means high impedance |
| osc_run | output | 1 | Oscillator run enable; 0 during power-down |
| vco_run | output | 1 | VCO run enable; 0 during power-down |

## Verification
The bench uses the default parameters. With these, the processor half period is 2 or 3 core cycles, the bus half period is 6 and the interrupt-controller half period is 6 or 12. Every normal-mode period and both strap settings therefore fit inside short windows. The test clock runs at a quarter of the core rate. This makes the fixed test ratios visible as exact counts of 4 to 64 cycles. Because the processor period is 4 cycles, a 3-cycle power-down pulse spans at most one processor rising edge. That pulse exercises the rejection path, while a held request exercises acceptance.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    FS_HIZ  = 2'b00,
    FS_TEST = 2'b01,
    FS_SLOW = 2'b10,
    FS_FAST = 2'b11
  } fsel_e;

  localparam int NGRP   = 8;
  localparam int GI_CPU = 0;
  localparam int GI_SDF = 1;
  localparam int GI_SDR = 2;
  localparam int GI_HUB = 3;
  localparam int GI_PCI = 4;
  localparam int GI_USB = 5;
  localparam int GI_REF = 6;
  localparam int GI_API = 7;
endpackage

// File: rtl/clkout_div.sv
// Half-period counter: ph toggles every 'half' core cycles.
module clkout_div #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] half,
  output logic          ph
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (cnt >= half - 1'b1) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkout_tdiv.sv
// Test-mode ratio tree: synchronized test clock plus a binary counter of its rising edges.
module clkout_tdiv #(
  parameter int TAPS = 4,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            tclk,
  output logic            ref_ph,
  output logic [TAPS-1:0] tap
);
  logic [SYNC:0] ts;
  logic          t_rise;

  always_ff @(posedge clk) begin
    if (rst) ts <= '0;
    else     ts <= {ts[SYNC-1:0], tclk};
  end

  assign t_rise = ts[SYNC-1] & ~ts[SYNC];

  always_ff @(posedge clk) begin
    if (rst) ref_ph <= 1'b0;
    else     ref_ph <= ts[SYNC-1];
  end

  always_ff @(posedge clk) begin
    if (rst || restart) tap <= '0;
    else if (t_rise)    tap <= tap + 1'b1;
  end
endmodule

// File: rtl/clkout_pdq.sv
// Power-down synchronizer and qualifier against processor-clock rising edges.
module clkout_pdq #(
  parameter int SYNC = 2,
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic cpu_rise,
  output logic pd_active
);
  localparam int QW = $clog2(QUAL + 1);

  logic [SYNC-1:0] sh;
  logic [QW-1:0]   cnt;
  logic            pd_s;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SYNC-2:0], pd_n};
  end

  assign pd_s = sh[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      pd_active <= 1'b0;
    end else if (pd_s) begin
      cnt       <= '0;
      pd_active <= 1'b0;
    end else if (cpu_rise && !pd_active) begin
      cnt <= cnt + 1'b1;
      if (cnt == QW'(QUAL - 1)) pd_active <= 1'b1;
    end
  end

  // R5: acceptance only on a processor rising edge seen with the request held low
  assert_pd_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> ($past(cpu_rise) && !$past(pd_s)));
endmodule

// File: rtl/clkout_gate.sv
// Glitch-free gate: the gate state may change only while the phase is low.
module clkout_gate (
  input  logic clk,
  input  logic rst,
  input  logic ph,
  input  logic req,
  output logic clk_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      clk_o  <= 1'b0;
    end else begin
      if (!ph) gate_q <= req;
      clk_o <= ph & gate_q;
    end
  end

  // R7: every falling output edge follows a falling phase edge, so no high pulse is cut short
  assert_full_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_o) |-> !$past(ph));
endmodule

// File: rtl/clkout_gate_seq.sv
module clkout_gate_seq
  import clkout_pkg::*;
#(
  parameter int N_CPU       = 3,
  parameter int N_SDR       = 8,
  parameter int N_HUB       = 2,
  parameter int N_PCI       = 7,
  parameter int N_USB       = 2,
  parameter int N_APIC      = 2,
  parameter int CW          = 5,
  parameter int CPU_HALF_HI = 2,
  parameter int CPU_HALF_LO = 3,
  parameter int SDR_HALF    = 2,
  parameter int HUB_HALF    = 3,
  parameter int PCI_HALF    = 6,
  parameter int USB_HALF    = 4,
  parameter int REF_HALF    = 14,
  parameter int APIC_HALF_HI = 6,
  parameter int SYNC        = 2,
  parameter int QUAL        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd_n,
  input  logic [1:0]        fsel,
  input  logic              tclk,
  input  logic              apic_fast,
  input  logic [N_CPU-1:0]  en_cpu,
  input  logic [N_SDR-1:0]  en_sdr,
  input  logic [N_PCI-1:0]  en_pci,
  input  logic [N_USB-1:0]  en_usb,
  output logic [N_CPU-1:0]  cpu_clk,
  output logic              sdr_free,
  output logic [N_SDR-1:0]  sdr_clk,
  output logic [N_HUB-1:0]  hub_clk,
  output logic [N_PCI-1:0]  pci_clk,
  output logic [N_USB-1:0]  usb_clk,
  output logic              ref_clk,
  output logic [N_APIC-1:0] apic_clk,
  output logic              drive_en,
  output logic              osc_run,
  output logic              vco_run
);
  localparam int TAPS = 4;

  fsel_e         fs_q, fs_d;
  logic          restart, test_mode;
  logic          apic_fast_q;
  logic          pd_active;
  logic          cpu_ph_d, cpu_rise;
  logic [CW-1:0] half_v [NGRP];
  logic [NGRP-1:0] nph, tph, ph;
  logic          t_ref;
  logic [TAPS-1:0] t_tap;

  // mode select register; a change restarts every divider
  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q <= FS_HIZ;
      fs_d <= FS_HIZ;
    end else begin
      fs_q <= fsel_e'(fsel);
      fs_d <= fs_q;
    end
  end

  assign restart   = (fs_q != fs_d);
  assign test_mode = (fs_q == FS_TEST);

  // rate strap, captured only during reset
  always_ff @(posedge clk) begin
    if (rst) apic_fast_q <= apic_fast;
  end

  // normal-mode half periods per group
  always_comb begin
    half_v[GI_CPU] = (fs_q == FS_SLOW) ? CW'(CPU_HALF_LO) : CW'(CPU_HALF_HI);
    half_v[GI_SDF] = CW'(SDR_HALF);
    half_v[GI_SDR] = CW'(SDR_HALF);
    half_v[GI_HUB] = CW'(HUB_HALF);
    half_v[GI_PCI] = CW'(PCI_HALF);
    half_v[GI_USB] = CW'(USB_HALF);
    half_v[GI_REF] = CW'(REF_HALF);
    half_v[GI_API] = apic_fast_q ? CW'(APIC_HALF_HI) : CW'(2 * APIC_HALF_HI);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_div
    clkout_div #(.CW(CW)) u_div (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .half    (half_v[g]),
      .ph      (nph[g])
    );
  end

  clkout_tdiv #(.TAPS(TAPS), .SYNC(SYNC)) u_tdiv (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tclk    (tclk),
    .ref_ph  (t_ref),
    .tap     (t_tap)
  );

  // fixed test ratios: tap[k] has period 2^(k+1) test clocks
  always_comb begin
    tph[GI_CPU] = t_tap[0];
    tph[GI_SDF] = t_tap[1];
    tph[GI_SDR] = t_tap[1];
    tph[GI_HUB] = t_tap[1];
    tph[GI_PCI] = t_tap[2];
    tph[GI_USB] = t_tap[0];
    tph[GI_REF] = t_ref;
    tph[GI_API] = t_tap[3];
  end

  assign ph = test_mode ? tph : nph;

  // processor rising edge taken from the ungated phase
  always_ff @(posedge clk) begin
    if (rst) cpu_ph_d <= 1'b0;
    else     cpu_ph_d <= ph[GI_CPU];
  end

  assign cpu_rise = ph[GI_CPU] & ~cpu_ph_d;

  clkout_pdq #(.SYNC(SYNC), .QUAL(QUAL)) u_pdq (
    .clk       (clk),
    .rst       (rst),
    .pd_n      (pd_n),
    .cpu_rise  (cpu_rise),
    .pd_active (pd_active)
  );

  // output gate cells
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    clkout_gate u_g (.clk(clk), .rst(rst), .ph(ph[GI_CPU]),
                     .req(en_cpu[i] & ~pd_active), .clk_o(cpu_clk[i]));
  end

  clkout_gate u_sdf (.clk(clk), .rst(rst), .ph(ph[GI_SDF]),
                     .req(~pd_active), .clk_o(sdr_free));

  for (genvar i = 0; i < N_SDR; i++) begin : g_sdr
    clkout_gate u_g (.clk(clk), .rst(rst), .ph(ph[GI_SDR]),
                     .req(en_sdr[i] & ~pd_active), .clk_o(sdr_clk[i]));
  end

  for (genvar i = 0; i < N_HUB; i++) begin : g_hub
    clkout_gate u_g (.clk(clk), .rst(rst), .ph(ph[GI_HUB]),
                     .req(~pd_active), .clk_o(hub_clk[i]));
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    clkout_gate u_g (.clk(clk), .rst(rst), .ph(ph[GI_PCI]),
                     .req(en_pci[i] & ~pd_active), .clk_o(pci_clk[i]));
  end

  for (genvar i = 0; i < N_USB; i++) begin : g_usb
    clkout_gate u_g (.clk(clk), .rst(rst), .ph(ph[GI_USB]),
                     .req(en_usb[i] & ~pd_active), .clk_o(usb_clk[i]));
  end

  clkout_gate u_ref (.clk(clk), .rst(rst), .ph(ph[GI_REF]),
                     .req(~pd_active), .clk_o(ref_clk));

  for (genvar i = 0; i < N_APIC; i++) begin : g_api
    clkout_gate u_g (.clk(clk), .rst(rst), .ph(ph[GI_API]),
                     .req(~pd_active), .clk_o(apic_clk[i]));
  end

  // pad and oscillator controls
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en <= 1'b0;
      osc_run  <= 1'b1;
      vco_run  <= 1'b1;
    end else begin
      drive_en <= (fs_q != FS_HIZ);
      osc_run  <= ~pd_active;
      vco_run  <= ~pd_active;
    end
  end

  logic any_out;
  assign any_out = |{cpu_clk, sdr_free, sdr_clk, hub_clk, pci_clk, usb_clk, ref_clk, apic_clk};

  // R6: no output rises once power-down has been held for two cycles
  assert_no_rise_in_pd_R6: assert property (@(posedge clk) disable iff (rst)
    (pd_active && $past(pd_active) && $past(pd_active, 2)) |-> !$rose(any_out));

  // R4: tristate code removes pad drive
  assert_hiz_drive_R4: assert property (@(posedge clk) disable iff (rst)
    (fs_q == FS_HIZ) |=> !drive_en);

  // R10: strap is frozen outside reset
  assert_strap_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(apic_fast_q));
endmodule

// File: tb/clkout_gate_seq_tb_top.sv
module clkout_gate_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pd_n = 1'b1;
  logic [1:0] fsel = 2'b11;
  logic       tclk = 1'b0;
  logic       apic_fast = 1'b1;
  logic [2:0] en_cpu = '1;
  logic [7:0] en_sdr = '1;
  logic [6:0] en_pci = '1;
  logic [1:0] en_usb = '1;
  logic [2:0] cpu_clk;
  logic       sdr_free;
  logic [7:0] sdr_clk;
  logic [1:0] hub_clk;
  logic [6:0] pci_clk;
  logic [1:0] usb_clk;
  logic       ref_clk;
  logic [1:0] apic_clk;
  logic       drive_en, osc_run, vco_run;

  always #5 clk = ~clk;
  initial begin
    #3;
    forever #20 tclk = ~tclk;
  end

  clkout_gate_seq dut_i (
    .clk(clk), .rst(rst), .pd_n(pd_n), .fsel(fsel), .tclk(tclk), .apic_fast(apic_fast),
    .en_cpu(en_cpu), .en_sdr(en_sdr), .en_pci(en_pci), .en_usb(en_usb),
    .cpu_clk(cpu_clk), .sdr_free(sdr_free), .sdr_clk(sdr_clk), .hub_clk(hub_clk),
    .pci_clk(pci_clk), .usb_clk(usb_clk), .ref_clk(ref_clk), .apic_clk(apic_clk),
    .drive_en(drive_en), .osc_run(osc_run), .vco_run(vco_run)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    int    sel;
    int    hi;
    int    lo;
    string tag;
  } exp_t;
  exp_t q[$];
  bit   mon_busy = 0;

  function automatic logic pick(int s);
    case (s)
      0: return cpu_clk[0];
      1: return sdr_clk[0];
      2: return sdr_free;
      3: return hub_clk[0];
      4: return pci_clk[0];
      5: return usb_clk[0];
      6: return ref_clk;
      7: return apic_clk[0];
      8: return sdr_clk[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic any_high();
    return |{cpu_clk, sdr_free, sdr_clk, hub_clk, pci_clk, usb_clk, ref_clk, apic_clk};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(int s, output int hi, output int lo);
    int guard;
    logic prev;
    hi = 0;
    lo = 0;
    guard = 0;
    @(negedge clk);
    prev = pick(s);
    while (!(prev == 1'b0 && pick(s) == 1'b1) || guard == 0) begin
      prev = pick(s);
      @(negedge clk);
      guard++;
      if (guard > 400) begin
        hi = -1; lo = -1;
        return;
      end
    end
    hi = 0;
    while (pick(s) && hi < 400) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pick(s) && lo < 400) begin lo++; @(negedge clk); end
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    int hi, lo;
    forever begin
      wait (q.size() > 0);
      mon_busy = 1;
      e = q.pop_front();
      measure(e.sel, hi, lo);
      total++;
      if (hi != e.hi || lo != e.lo) begin
        bad++;
        $display("FAIL %s actual=%0d/%0d expected=%0d/%0d", e.tag, hi, lo, e.hi, e.lo);
      end
      mon_busy = 0;
    end
  end

  task automatic expect_p(int s, int hi, int lo, string tag);
    exp_t e;
    e.sel = s; e.hi = hi; e.lo = lo; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    wait (q.size() == 0 && !mon_busy);
  endtask

  // every completed high run of the watched output must have width exp_hi
  task automatic watch(int s, int exp_hi, int cycles, string tag);
    int  run = 0;
    int  badw = exp_hi;
    bit  seen_low = 0;
    bit  ok = 1;
    int  pulses = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (pick(s)) begin
        if (seen_low) run++;
      end else begin
        if (run > 0) begin
          pulses++;
          if (run != exp_hi) begin ok = 0; badw = run; end
        end
        run = 0;
        seen_low = 1;
      end
    end
    check(ok && pulses > 0, tag, badw, exp_hi);
  endtask

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    int highs;
    // R1: reset state
    repeat (5) @(negedge clk);
    check(any_high() == 1'b0, "R1 outputs low in reset", int'(any_high()), 0);
    check(drive_en == 1'b0, "R1 drive_en low in reset", int'(drive_en), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // R2 fast processor rate and fixed groups; R10 strap=1
    expect_p(0, 2, 2, "R2 cpu fs=11");
    expect_p(1, 2, 2, "R2 sdram fs=11");
    expect_p(3, 3, 3, "R2 hub");
    expect_p(4, 6, 6, "R2 pci");
    expect_p(5, 4, 4, "R2 usb");
    expect_p(6, 14, 14, "R2 ref");
    expect_p(7, 6, 6, "R10 apic strap=1");
    drain();
    check(drive_en == 1'b1, "R4 drive_en in normal mode", int'(drive_en), 1);

    // R2 slow processor rate
    fsel = 2'b10;
    repeat (5) @(negedge clk);
    expect_p(0, 3, 3, "R2 cpu fs=10");
    expect_p(3, 3, 3, "R2 hub fs=10");
    drain();

    // R3 test ratios, test clock period 4 core cycles
    fsel = 2'b01;
    repeat (5) @(negedge clk);
    expect_p(6, 2, 2, "R3 ref = T");
    expect_p(0, 4, 4, "R3 cpu = T/2");
    expect_p(5, 4, 4, "R3 usb = T/2");
    expect_p(1, 8, 8, "R3 sdram = T/4");
    expect_p(3, 8, 8, "R3 hub = T/4");
    expect_p(4, 16, 16, "R3 pci = T/8");
    expect_p(7, 32, 32, "R3 apic = T/16");
    drain();

    // R4 tristate
    fsel = 2'b00;
    repeat (4) @(negedge clk);
    check(drive_en == 1'b0, "R4 drive_en off with select 00", int'(drive_en), 0);
    fsel = 2'b11;
    repeat (4) @(negedge clk);
    check(drive_en == 1'b1, "R4 drive_en back on", int'(drive_en), 1);
    repeat (10) @(negedge clk);

    // R8 single enable off
    en_sdr[0] = 1'b0;
    repeat (10) @(negedge clk);
    highs = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (sdr_clk[0]) highs++; end
    check(highs == 0, "R8 disabled sdram held low", highs, 0);
    expect_p(8, 2, 2, "R8 neighbour sdram keeps running");
    drain();

    // R9 free output ignores enables
    en_sdr = '0;
    en_cpu = '0;
    repeat (10) @(negedge clk);
    expect_p(2, 2, 2, "R9 free sdram with all enables 0");
    drain();
    highs = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (cpu_clk[0]) highs++; end
    check(highs == 0, "R8 disabled cpu held low", highs, 0);
    en_sdr = '1;
    en_cpu = '1;
    repeat (10) @(negedge clk);

    // R7 / R11 enable toggled mid-run
    fork
      watch(4, 6, 220, "R7 R11 pci pulses on enable stop and restart");
      begin
        repeat (37) @(negedge clk);
        en_pci[0] = 1'b0;
        repeat (80) @(negedge clk);
        en_pci[0] = 1'b1;
      end
    join
    expect_p(4, 6, 6, "R11 pci after re-enable");
    drain();

    // R5 short request rejected
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    pd_n = 1'b1;
    cnt = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (!osc_run) cnt++; end
    check(cnt == 0, "R5 short power-down pulse ignored", cnt, 0);

    // R5 accepted request latency; R7 on power-down entry
    fork
      begin
        cnt = 0;
        pd_n = 1'b0;
        while (osc_run && cnt < 50) begin @(negedge clk); cnt++; end
        check(cnt >= 6 && cnt <= 13, "R5 power-down accepted after two cpu edges", cnt, 10);
      end
      watch(4, 6, 70, "R7 pci last pulse full on power-down");
    join

    // R6 everything parked
    repeat (40) @(negedge clk);
    highs = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (any_high()) highs++; end
    check(highs == 0, "R6 all outputs low in power-down", highs, 0);
    check(osc_run == 1'b0 && vco_run == 1'b0, "R6 osc and vco disabled",
          int'({osc_run, vco_run}), 0);

    // R11 release
    fork
      watch(4, 6, 120, "R11 pci first pulse full after release");
      watch(0, 2, 120, "R11 cpu first pulse full after release");
      begin @(negedge clk); pd_n = 1'b1; end
    join
    check(osc_run == 1'b1 && vco_run == 1'b1, "R11 osc and vco running again",
          int'({osc_run, vco_run}), 3);

    // R10 strap held and re-captured
    apic_fast = 1'b0;
    repeat (5) @(negedge clk);
    expect_p(7, 6, 6, "R10 strap change after reset ignored");
    drain();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    expect_p(7, 12, 12, "R10 strap=0 gives half rate");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule